// File: doc/BRIEF.md
# Stacked-Die Channel Driver Enable Decoder

Each die in a stack of identical DRAM dies is wired to the through-silicon buses of every channel. It may electrically drive only the buses it has been granted. This block is the per-die control for that. It takes the die's fuse-programmed stack identity and checks it. It then decides, for each of the die's pseudo-channel ports, which single channel bus that port's tri-state drivers are connected to. A die with no valid identity drives nothing.

Commands reach the die with three pieces of routing information: the bus they arrived on, their home channel tag and a pseudo-channel select. Normally a die takes a command only from its own channel's bus. When the reroute strobe is high, the command is one that a neighbouring controller migrated. The die then matches on the home tag instead, and it connects the selected port to the foreign bus the command came in on. This returns the request to the die that holds its data.

Enables are registered and change only when a command is accepted. A port that moves from one bus to another is switched off for one cycle before it drives the new bus. Two ports of the same die never drive the same bus.

Top module: `sid_chan_drv_dec`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `drv_en` is 0 and `cmd_accept` is 0.
- R2: An identity is valid when `fuse_id` is below NUM_DIES (8). The unfused value all ones (15) and every other value from 8 to 14 are invalid. While the identity is invalid, `drv_en` is all zero, starting at once, and no command is accepted. The stored port state is cleared at the next clock edge, so restoring a valid identity re-enables nothing until a new command is accepted.
- R3: With `reroute` low, a command with `cmd_valid` high is accepted when `cmd_bus` equals the die identity. `cmd_accept` is high for exactly the cycle after the command. Port `cmd_pc` is then assigned bus `cmd_bus`.
- R4: With `reroute` high, a command is accepted when `cmd_home` equals the die identity, whatever `cmd_bus` is. Port `cmd_pc` is then assigned the arrival bus `cmd_bus`. A rerouted command whose home tag differs is not accepted, even when it arrives on the die's own bus.
- R5: A command that is not accepted leaves `cmd_accept` low and leaves `drv_en` unchanged.
- R6: Bit `p*NUM_CH + b` of `drv_en` (with NUM_CH = 8) means port `p` drives bus `b`. Each port's 8-bit group is one-hot or zero.
- R7: With no accepted command, `drv_en` holds its value from cycle to cycle.
- R8: A port that is idle, or that is reloaded with the bus it already drives, shows the new enable in the cycle after the command. A port that is moved from driving bus A to a different bus B shows all zero for that cycle, and shows B one cycle later.
- R9: A port that is assigned a bus which another port of the same die drives, or is waiting to drive, causes that other port to release the bus at the same clock edge. No bus is ever enabled on two ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fuse_id | input | 4 | Fuse-programmed stack identity; all ones means unfused |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_bus | input | 3 | Channel bus the command arrived on |
| cmd_home | input | 3 | Home channel tag of the command |
| cmd_pc | input | 1 | Pseudo-channel port the command addresses |
| reroute | input | 1 | Command is a migrated request; match on home tag |
| cmd_accept | output | 1 | Pulse: this die took the previous cycle's command |
| drv_en | output | 16 | Tri-state enables, bit p*8+b drives bus b from port p |

## Verification
A port left in a wrong state drives the wrong bus, or fails to drop one. This shows on `drv_en` at the first sampling point after the accepting edge, because the enables sit one register from the inputs. A missed turnaround shows as a direct jump between two non-zero values in a single cycle. A missed release shows as one bus bit set in both port groups. A wrong match decision shows on `cmd_accept` in the cycle after the command, together with an unchanged or wrongly changed `drv_en`. State that survives an invalid identity shows up as soon as the identity becomes valid again.

// File: rtl/sid_pkg.sv
package sid_pkg;
   // default geometry of the stack
   localparam int DFLT_DIES  = 8;
   localparam int DFLT_PC    = 2;
   localparam int DFLT_ID_W  = 4;

   // per-port driver state
   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_DRIVE = 2'd1,
      PS_GAP   = 2'd2
   } port_state_e;
endpackage

// File: rtl/sid_fuse_dec.sv
module sid_fuse_dec #(
   parameter int NUM_DIES = sid_pkg::DFLT_DIES,
   parameter int ID_W     = sid_pkg::DFLT_ID_W,
   localparam int CH_W    = $clog2(NUM_DIES)
) (
   input  logic [ID_W-1:0] fuse_id,
   output logic            id_ok,
   output logic [CH_W-1:0] own_bus
);
   if (NUM_DIES < 2) begin : g_bad_dies
      $error("sid_fuse_dec: NUM_DIES must be at least 2");
   end
   if ((2 ** ID_W) - 1 < NUM_DIES) begin : g_bad_idw
      $error("sid_fuse_dec: all-ones identity must be out of range");
   end

   if (NUM_DIES == (1 << CH_W)) begin : g_pow2
      // power-of-two die count: valid iff upper identity bits are zero
      assign id_ok = (fuse_id[ID_W-1:CH_W] == '0);
   end else begin : g_range
      assign id_ok = (fuse_id < ID_W'(NUM_DIES));
   end

   assign own_bus = fuse_id[CH_W-1:0];
endmodule

// File: rtl/sid_cmd_match.sv
module sid_cmd_match #(
   parameter int NUM_CH    = sid_pkg::DFLT_DIES,
   parameter int PC_PER_CH = sid_pkg::DFLT_PC,
   localparam int CH_W     = $clog2(NUM_CH),
   localparam int PC_W     = (PC_PER_CH > 1) ? $clog2(PC_PER_CH) : 1
) (
   input  logic                 id_ok,
   input  logic [CH_W-1:0]      own_bus,
   input  logic                 cmd_valid,
   input  logic [CH_W-1:0]      cmd_bus,
   input  logic [CH_W-1:0]      cmd_home,
   input  logic [PC_W-1:0]      cmd_pc,
   input  logic                 reroute,
   output logic                 take,
   output logic [NUM_CH-1:0]    take_bus,
   output logic [PC_PER_CH-1:0] take_pc
);
   logic tag_hit;
   logic pc_in_range;

   // rerouted traffic matches on home tag, regular traffic on arrival bus
   assign tag_hit     = reroute ? (cmd_home == own_bus) : (cmd_bus == own_bus);
   assign pc_in_range = (32'(cmd_pc) < PC_PER_CH);
   assign take        = id_ok & cmd_valid & tag_hit & pc_in_range;

   for (genvar b = 0; b < NUM_CH; b++) begin : g_bus
      assign take_bus[b] = (cmd_bus == CH_W'(b));
   end

   for (genvar p = 0; p < PC_PER_CH; p++) begin : g_pc
      assign take_pc[p] = take & (cmd_pc == PC_W'(p));
   end

   // R6
   // take_pc_onehot_chk
   always_comb begin
      take_pc_onehot_chk : assert ($onehot0(take_pc));
   end
endmodule

// File: rtl/sid_port_drv.sv
module sid_port_drv #(
   parameter int NUM_CH = sid_pkg::DFLT_DIES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [NUM_CH-1:0] load_bus,
   input  logic [NUM_CH-1:0] rel,
   output logic [NUM_CH-1:0] en
);
   import sid_pkg::*;

   port_state_e       st_q;
   logic [NUM_CH-1:0] cur_q;
   logic              hit_rel;

   assign hit_rel = |(cur_q & rel);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         st_q  <= PS_IDLE;
         cur_q <= '0;
      end else if (load) begin
         // switching a live driver to a new bus goes through a dead cycle
         if (st_q == PS_DRIVE && cur_q != load_bus) st_q <= PS_GAP;
         else                                      st_q <= PS_DRIVE;
         cur_q <= load_bus;
      end else if (hit_rel && st_q != PS_IDLE) begin
         st_q  <= PS_IDLE;
         cur_q <= '0;
      end else if (st_q == PS_GAP) begin
         st_q <= PS_DRIVE;
      end
   end

   assign en = (st_q == PS_DRIVE) ? cur_q : '0;

   // R6
   // en_onehot_chk
   en_onehot_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en));

   // R8
   // no_direct_switch_chk
   no_direct_switch_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (en != '0 && $past(en) != '0) |-> (en == $past(en)));

   // R8
   // gap_then_drive_chk
   gap_then_drive_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_GAP && !clr && !load && !hit_rel) |=> (en == $past(cur_q)));

   // R7
   // hold_chk
   hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != PS_GAP && !clr && !load && !hit_rel) |=> $stable(en));
endmodule

// File: rtl/sid_chan_drv_dec.sv
module sid_chan_drv_dec #(
   parameter int NUM_DIES  = sid_pkg::DFLT_DIES,
   parameter int PC_PER_CH = sid_pkg::DFLT_PC,
   parameter int ID_W      = sid_pkg::DFLT_ID_W,
   localparam int NUM_CH   = NUM_DIES,
   localparam int CH_W     = $clog2(NUM_CH),
   localparam int PC_W     = (PC_PER_CH > 1) ? $clog2(PC_PER_CH) : 1,
   localparam int EN_W     = NUM_CH * PC_PER_CH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] fuse_id,
   input  logic            cmd_valid,
   input  logic [CH_W-1:0] cmd_bus,
   input  logic [CH_W-1:0] cmd_home,
   input  logic [PC_W-1:0] cmd_pc,
   input  logic            reroute,
   output logic            cmd_accept,
   output logic [EN_W-1:0] drv_en
);
   if (PC_PER_CH < 1) begin : g_bad_pc
      $error("sid_chan_drv_dec: PC_PER_CH must be at least 1");
   end

   logic                 id_ok;
   logic [CH_W-1:0]      own_bus;
   logic                 take;
   logic [NUM_CH-1:0]    take_bus;
   logic [PC_PER_CH-1:0] take_pc;
   logic                 accept_q;
   logic [NUM_CH-1:0]    en_a  [PC_PER_CH];
   logic [NUM_CH-1:0]    rel_a [PC_PER_CH];

   sid_fuse_dec #(.NUM_DIES(NUM_DIES), .ID_W(ID_W)) i_fuse (
      .fuse_id (fuse_id),
      .id_ok   (id_ok),
      .own_bus (own_bus)
   );

   sid_cmd_match #(.NUM_CH(NUM_CH), .PC_PER_CH(PC_PER_CH)) i_match (
      .id_ok     (id_ok),
      .own_bus   (own_bus),
      .cmd_valid (cmd_valid),
      .cmd_bus   (cmd_bus),
      .cmd_home  (cmd_home),
      .cmd_pc    (cmd_pc),
      .reroute   (reroute),
      .take      (take),
      .take_bus  (take_bus),
      .take_pc   (take_pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) accept_q <= 1'b0;
      else        accept_q <= take;
   end
   assign cmd_accept = accept_q;

   for (genvar p = 0; p < PC_PER_CH; p++) begin : g_port
      // a bus granted to any other port is released by this one
      always_comb begin
         rel_a[p] = '0;
         for (int q = 0; q < PC_PER_CH; q++) begin
            if (q != p && take_pc[q]) rel_a[p] = take_bus;
         end
      end

      sid_port_drv #(.NUM_CH(NUM_CH)) i_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (!id_ok),
         .load     (take_pc[p]),
         .load_bus (take_bus),
         .rel      (rel_a[p]),
         .en       (en_a[p])
      );

      assign drv_en[p*NUM_CH +: NUM_CH] = en_a[p] & {NUM_CH{id_ok}};
   end

   for (genvar b = 0; b < NUM_CH; b++) begin : g_col
      logic [PC_PER_CH-1:0] col;
      for (genvar p = 0; p < PC_PER_CH; p++) begin : g_bit
         assign col[p] = drv_en[p*NUM_CH + b];
      end
      // R9
      // bus_single_driver_chk
      bus_single_driver_chk : assert property (@(posedge clk) disable iff (!rst_n)
         $countones(col) <= 1);
   end

   // R2
   // unfused_off_chk
   unfused_off_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (&fuse_id) |-> (drv_en == '0));

   // R3
   // accept_follows_cmd_chk
   accept_follows_cmd_chk : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept |-> $past(cmd_valid));

   // R2
   // no_accept_unfused_chk
   no_accept_unfused_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (&fuse_id) |=> !cmd_accept);
endmodule

// File: tb/test_sid_chan_drv_dec.sv
`timescale 1ns/1ps
module test_sid_chan_drv_dec;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  fuse_id;
   logic        cmd_valid;
   logic [2:0]  cmd_bus;
   logic [2:0]  cmd_home;
   logic [0:0]  cmd_pc;
   logic        reroute;
   logic        cmd_accept;
   logic [15:0] drv_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sid_chan_drv_dec i_sid_chan_drv_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .fuse_id    (fuse_id),
      .cmd_valid  (cmd_valid),
      .cmd_bus    (cmd_bus),
      .cmd_home   (cmd_home),
      .cmd_pc     (cmd_pc),
      .reroute    (reroute),
      .cmd_accept (cmd_accept),
      .drv_en     (drv_en)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one command for a single edge; returns at the negedge after it
   task automatic send(input int bus, input int home, input int pc, input bit rr);
      cmd_valid = 1'b1;
      cmd_bus   = 3'(bus);
      cmd_home  = 3'(home);
      cmd_pc    = 1'(pc);
      reroute   = rr;
      @(negedge clk);
      cmd_valid = 1'b0;
      reroute   = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; fuse_id = 4'd3; cmd_valid = 1'b0;
      cmd_bus = '0; cmd_home = '0; cmd_pc = '0; reroute = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 en in reset", drv_en, 16'h0000);
      chk("R1 accept in reset", {15'd0, cmd_accept}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 en after reset", drv_en, 16'h0000);
   endtask

   task automatic t_invalid_id();
      fuse_id = 4'hF;
      send(3, 3, 0, 1'b0);
      chk("R2 unfused accept", {15'd0, cmd_accept}, 16'h0000);
      chk("R2 unfused en", drv_en, 16'h0000);
      fuse_id = 4'd9;
      send(1, 1, 0, 1'b0);
      chk("R2 out-of-range accept", {15'd0, cmd_accept}, 16'h0000);
      chk("R2 out-of-range en", drv_en, 16'h0000);
      fuse_id = 4'd3;
      @(negedge clk);
   endtask

   task automatic t_normal();
      send(3, 0, 0, 1'b0);
      chk("R3 own bus accept", {15'd0, cmd_accept}, 16'h0001);
      chk("R3 R6 port0 bus3", drv_en, 16'h0008);
      @(negedge clk);
      chk("R3 accept is a pulse", {15'd0, cmd_accept}, 16'h0000);
   endtask

   task automatic t_ignored();
      send(5, 5, 1, 1'b0);
      chk("R5 foreign bus accept", {15'd0, cmd_accept}, 16'h0000);
      chk("R5 foreign bus en", drv_en, 16'h0008);
      send(3, 6, 1, 1'b1);
      chk("R4 reroute home mismatch accept", {15'd0, cmd_accept}, 16'h0000);
      chk("R4 reroute home mismatch en", drv_en, 16'h0008);
   endtask

   task automatic t_reroute();
      send(5, 3, 1, 1'b1);
      chk("R4 reroute accept", {15'd0, cmd_accept}, 16'h0001);
      chk("R4 port1 drives arrival bus5", drv_en, 16'h2008);
   endtask

   task automatic t_hold();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R7 hold en", drv_en, 16'h2008);
      end
   endtask

   task automatic t_gap();
      send(2, 3, 1, 1'b1);
      chk("R8 turnaround dead cycle", drv_en, 16'h0008);
      @(negedge clk);
      chk("R8 new bus after gap", drv_en, 16'h0408);
      send(2, 3, 1, 1'b1);
      chk("R8 same-bus reload no gap", drv_en, 16'h0408);
   endtask

   task automatic t_exclusive();
      send(3, 0, 1, 1'b0);
      chk("R9 port0 released, port1 in gap", drv_en, 16'h0000);
      @(negedge clk);
      chk("R9 port1 takes bus3", drv_en, 16'h0800);
      send(6, 3, 0, 1'b1);
      chk("R8 idle port drives directly", drv_en, 16'h0840);
   endtask

   task automatic t_fuse_drop();
      fuse_id = 4'hF;
      #1;
      chk("R2 unfused drops enables at once", drv_en, 16'h0000);
      @(negedge clk);
      chk("R2 unfused enables stay off", drv_en, 16'h0000);
      fuse_id = 4'd3;
      @(negedge clk);
      chk("R2 state cleared on restore", drv_en, 16'h0000);
   endtask

   initial begin
      t_reset();
      t_invalid_id();
      t_normal();
      t_ignored();
      t_reroute();
      t_hold();
      t_gap();
      t_exclusive();
      t_fuse_drop();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule